// File: doc/BRIEF.md
# Instruction Cache Lookup with TLB-Linked Tags

This block is the lookup path of a 16-Kbyte, four-way set-associative instruction cache. Its tags hold no physical address. Each way of each set stores a 32-bit one-hot vector. That vector names the entry of a 32-entry, fully associative first-level TLB that translates the line. The TLB compares the virtual page number of a fetch address against every valid entry and produces a match-line vector. A way hits when its stored vector shares a set bit with the match lines. The per-way hit vector then steers the read of the data array. A fetch that misses the TLB drives no match lines, so it can never hit the cache.

A fetch address is presented with `req_valid`. One cycle later the block returns a 32-byte slice (two 16-byte bundles) of the 64-byte line, together with hit, miss, TLB-miss and error flags. The set index comes from address bits [11:6], which lie inside the 4-Kbyte page offset. Bit 5 picks the half of the line. The TLB maps only 4-Kbyte pages, so a larger page takes one entry for each 4-Kbyte piece that is used.

A fill writes a whole line into a chosen way and stores, as its tag, the match-line vector of the fill address. Writing a TLB entry clears that entry's bit in every tag of the cache, so lines translated by the old contents stop hitting. Miss handling beyond the flags is left to the surrounding logic.

Top module: `pvt_icache_lookup`

## Requirements
- R1: While reset is applied, and for the two cycles after `rst_n` rises, `rsp_valid` is 0. Reset leaves every TLB entry invalid and every tag vector zero.
- R2: A request taken with `req_valid` at one clock edge gives `rsp_valid`=1 after the next edge only. When `rsp_valid` is 0, `rsp_hit`, `rsp_miss`, `rsp_perr`, `rsp_tlb_miss` and `rsp_way` are all 0. When it is 1, exactly one of `rsp_hit`, `rsp_miss` and `rsp_perr` is 1.
- R3: A way hits when its tag vector in set `req_vaddr[11:6]` ANDed with the match lines is nonzero. An entry matches when it is valid and its page number equals `req_vaddr[47:12]`. On a single hit, `rsp_way` is one-hot (bit w = way w). `rsp_data` holds bytes 32*`req_vaddr[5]` to 32*`req_vaddr[5]`+31 of the line, with byte 0 in bits [7:0]. Address bits [4:0] have no effect.
- R4: When no TLB entry matches, `rsp_tlb_miss` and `rsp_miss` are 1 and `rsp_hit` is 0.
- R5: A fill writes `fill_data` into way `fill_way` of set `fill_vaddr[11:6]`, and writes the match-line vector of `fill_vaddr` as that way's tag. A line filled while its address misses the TLB never hits afterwards.
- R6: Writing TLB entry e clears bit e of every tag. Lines filled through entry e then miss, even when e is rewritten with the same page number.
- R7: A response reflects the TLB, tags and data as they were before any same-cycle fill or TLB write. A fill in the same cycle as a write to entry e stores a tag with bit e cleared.
- R8: When two or more ways hit, `rsp_perr` is 1, `rsp_hit` and `rsp_miss` are 0, `rsp_way` shows every hitting way, and `rsp_data` is zero.
- R9: On a miss, `rsp_way` and `rsp_data` are zero.
- R10: A fill changes only its target way. The other ways of the set and all other sets keep their tags and data.
- R11: An address that hits the TLB but whose set holds no way tagged with a matching entry gives `rsp_miss`=1 with `rsp_tlb_miss`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Lookup request this cycle |
| req_vaddr | input | 48 | Virtual fetch address |
| tlb_wr_en | input | 1 | Write a TLB entry this cycle |
| tlb_wr_idx | input | 5 | Index of the TLB entry written |
| tlb_wr_vpn | input | 36 | Virtual page number stored in that entry |
| fill_valid | input | 1 | Line fill this cycle |
| fill_vaddr | input | 48 | Virtual address of the filled line |
| fill_way | input | 2 | Way that receives the fill |
| fill_data | input | 512 | Line contents, byte 0 in bits [7:0] |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_hit | output | 1 | Exactly one way hit |
| rsp_miss | output | 1 | No way hit |
| rsp_tlb_miss | output | 1 | No TLB entry matched |
| rsp_way | output | 4 | Hitting ways, one bit per way |
| rsp_data | output | 256 | 32-byte read slice, zero unless a single hit |
| rsp_perr | output | 1 | More than one way hit |

## Verification
A stale bit left in a tag shows up as a false hit or a spurious `rsp_perr` on the first lookup that reaches that set after a TLB entry is rewritten. A lost fill bit shows up as a miss on the very next lookup of that line. A wrong way select or a wrong half select puts another line's bytes on `rsp_data` in the response cycle. A mask that fails during a same-cycle fill and TLB write only appears on a later lookup of the filled set. For that reason each state change is followed by lookups that reach the affected set and the neighbouring ways.

// File: rtl/pvt_ic_pkg.sv
package pvt_ic_pkg;
  localparam int unsigned DEF_VA_W        = 48;
  localparam int unsigned DEF_TLB_N       = 32;
  localparam int unsigned DEF_WAYS        = 4;
  localparam int unsigned DEF_CACHE_BYTES = 16384;
  localparam int unsigned DEF_LINE_BYTES  = 64;
  localparam int unsigned DEF_READ_BYTES  = 32;
  localparam int unsigned PAGE_BITS       = 12;
endpackage

// File: rtl/pvt_tlb_cam.sv
module pvt_tlb_cam #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned VPN_W   = 36,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [VPN_W-1:0]   fl_vpn,
  output logic [ENTRIES-1:0] lk_match,
  output logic [ENTRIES-1:0] fl_match
);
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) vpn_q[wr_idx] <= wr_vpn;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign lk_match[e] = valid_q[e] && (vpn_q[e] == lk_vpn);
    assign fl_match[e] = valid_q[e] && (vpn_q[e] == fl_vpn);
  end
endmodule

// File: rtl/pvt_tag_array.sv
module pvt_tag_array #(
  parameter int unsigned SETS    = 64,
  parameter int unsigned WAYS    = 4,
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned SET_W  = $clog2(SETS),
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SET_W-1:0]   rd_set,
  input  logic [ENTRIES-1:0] rd_match,
  output logic [WAYS-1:0]    way_hit,
  input  logic               clr_en,
  input  logic [IDX_W-1:0]   clr_idx,
  input  logic               fill_en,
  input  logic [SET_W-1:0]   fill_set,
  input  logic [WAY_W-1:0]   fill_way,
  input  logic [ENTRIES-1:0] fill_vec
);
  logic [ENTRIES-1:0] tag_q [SETS][WAYS];
  logic [ENTRIES-1:0] tag_d [SETS][WAYS];

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        tag_d[s][w] = tag_q[s][w];
        if (clr_en) tag_d[s][w][clr_idx] = 1'b0;
        if (fill_en && (fill_set == SET_W'(s)) && (fill_way == WAY_W'(w)))
          tag_d[s][w] = fill_vec;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          tag_q[s][w] <= '0;
    end else if (clr_en || fill_en) begin
      tag_q <= tag_d;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_hit
    assign way_hit[w] = |(tag_q[rd_set][w] & rd_match);
  end
endmodule

// File: rtl/pvt_data_array.sv
module pvt_data_array #(
  parameter int unsigned SETS   = 64,
  parameter int unsigned WAYS   = 4,
  parameter int unsigned LINE_W = 512,
  parameter int unsigned READ_W = 256,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned PART_W = (LINE_W / READ_W > 1) ? $clog2(LINE_W / READ_W) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [PART_W-1:0] rd_part,
  input  logic [WAYS-1:0]   way_sel,
  output logic [READ_W-1:0] rd_data
);
  logic [LINE_W-1:0] mem_q [SETS*WAYS];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[{wr_set, wr_way}] <= wr_line;
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_sel[w])
        rd_data = rd_data | mem_q[{rd_set, WAY_W'(w)}][int'(rd_part)*READ_W +: READ_W];
    end
  end
endmodule

// File: rtl/pvt_icache_lookup.sv
module pvt_icache_lookup
  import pvt_ic_pkg::*;
#(
  parameter int unsigned VA_W        = DEF_VA_W,
  parameter int unsigned TLB_N       = DEF_TLB_N,
  parameter int unsigned WAYS        = DEF_WAYS,
  parameter int unsigned CACHE_BYTES = DEF_CACHE_BYTES,
  parameter int unsigned LINE_BYTES  = DEF_LINE_BYTES,
  parameter int unsigned READ_BYTES  = DEF_READ_BYTES,
  localparam int unsigned SETS     = CACHE_BYTES / (WAYS * LINE_BYTES),
  localparam int unsigned SET_W    = $clog2(SETS),
  localparam int unsigned WAY_W    = $clog2(WAYS),
  localparam int unsigned IDX_W    = $clog2(TLB_N),
  localparam int unsigned OFF_W    = $clog2(LINE_BYTES),
  localparam int unsigned RD_OFF_W = $clog2(READ_BYTES),
  localparam int unsigned PART_W   = OFF_W - RD_OFF_W,
  localparam int unsigned LINE_W   = LINE_BYTES * 8,
  localparam int unsigned READ_W   = READ_BYTES * 8,
  localparam int unsigned VPN_W    = VA_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              tlb_wr_en,
  input  logic [IDX_W-1:0]  tlb_wr_idx,
  input  logic [VPN_W-1:0]  tlb_wr_vpn,
  input  logic              fill_valid,
  input  logic [VA_W-1:0]   fill_vaddr,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [LINE_W-1:0] fill_data,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_tlb_miss,
  output logic [WAYS-1:0]   rsp_way,
  output logic [READ_W-1:0] rsp_data,
  output logic              rsp_perr
);
  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // Address fields. The set index lies inside the page offset.
  logic [SET_W-1:0]  req_set, fill_set;
  logic [PART_W-1:0] req_part;
  logic [VPN_W-1:0]  req_vpn, fill_vpn;
  logic              unused_addr;

  assign req_set     = req_vaddr[OFF_W +: SET_W];
  assign req_part    = req_vaddr[RD_OFF_W +: PART_W];
  assign req_vpn     = req_vaddr[VA_W-1:PAGE_BITS];
  assign fill_set    = fill_vaddr[OFF_W +: SET_W];
  assign fill_vpn    = fill_vaddr[VA_W-1:PAGE_BITS];
  assign unused_addr = ^{req_vaddr[RD_OFF_W-1:0], fill_vaddr[OFF_W-1:0]};

  logic [TLB_N-1:0] lk_match, fl_match, fill_vec, repl_mask;
  logic [WAYS-1:0]  way_hit;
  logic [READ_W-1:0] rd_slice;

  pvt_tlb_cam #(.ENTRIES(TLB_N), .VPN_W(VPN_W)) u_tlb (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(tlb_wr_en), .wr_idx(tlb_wr_idx), .wr_vpn(tlb_wr_vpn),
    .lk_vpn(req_vpn), .fl_vpn(fill_vpn),
    .lk_match(lk_match), .fl_match(fl_match)
  );

  // An entry replaced in the fill cycle must not be linked to the new line.
  assign repl_mask = tlb_wr_en ? (TLB_N'(1) << tlb_wr_idx) : '0;
  assign fill_vec  = fl_match & ~repl_mask;

  pvt_tag_array #(.SETS(SETS), .WAYS(WAYS), .ENTRIES(TLB_N)) u_tags (
    .clk(clk), .rst_n(rst_sync_n),
    .rd_set(req_set), .rd_match(lk_match), .way_hit(way_hit),
    .clr_en(tlb_wr_en), .clr_idx(tlb_wr_idx),
    .fill_en(fill_valid), .fill_set(fill_set), .fill_way(fill_way),
    .fill_vec(fill_vec)
  );

  pvt_data_array #(.SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W), .READ_W(READ_W)) u_data (
    .clk(clk),
    .wr_en(fill_valid), .wr_set(fill_set), .wr_way(fill_way), .wr_line(fill_data),
    .rd_set(req_set), .rd_part(req_part), .way_sel(way_hit), .rd_data(rd_slice)
  );

  // Response next state
  logic              multi_hit, single_hit;
  logic              valid_d, hit_d, miss_d, tlbm_d, perr_d;
  logic [WAYS-1:0]   way_d;
  logic [READ_W-1:0] data_d;

  assign multi_hit  = |(way_hit & (way_hit - WAYS'(1)));
  assign single_hit = (|way_hit) && !multi_hit;

  always_comb begin
    valid_d = req_valid;
    hit_d   = req_valid && single_hit;
    miss_d  = req_valid && !(|way_hit);
    perr_d  = req_valid && multi_hit;
    tlbm_d  = req_valid && !(|lk_match);
    way_d   = req_valid ? way_hit : '0;
    data_d  = (req_valid && single_hit) ? rd_slice : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_miss     <= 1'b0;
      rsp_tlb_miss <= 1'b0;
      rsp_perr     <= 1'b0;
      rsp_way      <= '0;
      rsp_data     <= '0;
    end else begin
      rsp_valid    <= valid_d;
      rsp_hit      <= hit_d;
      rsp_miss     <= miss_d;
      rsp_tlb_miss <= tlbm_d;
      rsp_perr     <= perr_d;
      rsp_way      <= way_d;
      rsp_data     <= data_d;
    end
  end
endmodule

// File: rtl/pvt_icache_lookup_chk.sv
module pvt_icache_lookup_chk #(
  parameter int unsigned WAYS   = 4,
  parameter int unsigned READ_W = 256
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic              rsp_tlb_miss,
  input logic [WAYS-1:0]   rsp_way,
  input logic [READ_W-1:0] rsp_data,
  input logic              rsp_perr
);
  // R2: a response follows each request after exactly one edge
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);
  a_r2_no_rsp_without_req: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !rsp_valid);
  // R2: flags quiet when idle, one outcome when valid
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rsp_valid |-> !rsp_hit && !rsp_miss && !rsp_perr && !rsp_tlb_miss && (rsp_way == '0));
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_perr}) == 1);
  // R3: a hit names exactly one way
  a_r3_hit_one_way: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_hit |-> $countones(rsp_way) == 1);
  // R4: a TLB miss is always a cache miss
  a_r4_tlb_miss_is_miss: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_tlb_miss |-> rsp_miss && !rsp_hit);
  // R8: error means several ways and no data
  a_r8_perr_multi_way: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_perr |-> ($countones(rsp_way) > 1) && (rsp_data == '0));
  // R9: a miss carries no way and no data
  a_r9_miss_empty: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_miss |-> (rsp_way == '0) && (rsp_data == '0));
endmodule

bind pvt_icache_lookup pvt_icache_lookup_chk #(.WAYS(WAYS), .READ_W(READ_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .req_valid(req_valid),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
  .rsp_tlb_miss(rsp_tlb_miss), .rsp_way(rsp_way), .rsp_data(rsp_data),
  .rsp_perr(rsp_perr)
);

// File: tb/tb_pvt_icache_lookup.sv
module tb_pvt_icache_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W  = 48;
  localparam int VPN_W = 36;
  localparam int NTLB  = 32;
  localparam int NSET  = 64;
  localparam int NWAY  = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid;
  logic [VA_W-1:0]  req_vaddr;
  logic             tlb_wr_en;
  logic [4:0]       tlb_wr_idx;
  logic [VPN_W-1:0] tlb_wr_vpn;
  logic             fill_valid;
  logic [VA_W-1:0]  fill_vaddr;
  logic [1:0]       fill_way;
  logic [511:0]     fill_data;
  logic             rsp_valid, rsp_hit, rsp_miss, rsp_tlb_miss, rsp_perr;
  logic [3:0]       rsp_way;
  logic [255:0]     rsp_data;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pvt_icache_lookup dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr),
    .tlb_wr_en(tlb_wr_en), .tlb_wr_idx(tlb_wr_idx), .tlb_wr_vpn(tlb_wr_vpn),
    .fill_valid(fill_valid), .fill_vaddr(fill_vaddr), .fill_way(fill_way),
    .fill_data(fill_data),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_tlb_miss(rsp_tlb_miss), .rsp_way(rsp_way), .rsp_data(rsp_data),
    .rsp_perr(rsp_perr)
  );

  // Reference state, built from the requirements
  bit               m_tv   [NTLB];
  logic [VPN_W-1:0] m_tvpn [NTLB];
  logic [NTLB-1:0]  m_tag  [NSET][NWAY];
  logic [511:0]     m_dat  [NSET][NWAY];

  function automatic logic [VA_W-1:0] mk_va(logic [VPN_W-1:0] vpn, int set, int low);
    return {vpn, 6'(set), 6'(low)};
  endfunction

  function automatic logic [NTLB-1:0] match_of(logic [VA_W-1:0] va);
    logic [NTLB-1:0] m = '0;
    for (int e = 0; e < NTLB; e++)
      if (m_tv[e] && m_tvpn[e] == va[VA_W-1:12]) m[e] = 1'b1;
    return m;
  endfunction

  function automatic logic [511:0] rnd_line();
    logic [511:0] l;
    for (int i = 0; i < 16; i++) l[i*32 +: 32] = $urandom;
    return l;
  endfunction

  task automatic check(bit ok, string rq, string what, logic [255:0] act, logic [255:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, compare at the next falling edge.
  task automatic step(bit rv, logic [VA_W-1:0] rva,
                      bit tw, int ti, logic [VPN_W-1:0] tvpn,
                      bit fv, logic [VA_W-1:0] fva, int fw, logic [511:0] fd,
                      string rq);
    logic [NTLB-1:0] m, fm;
    logic [3:0]      wh;
    int              cnt, s, fs;
    logic [255:0]    ed;
    req_valid = rv;  req_vaddr = rva;
    tlb_wr_en = tw;  tlb_wr_idx = 5'(ti); tlb_wr_vpn = tvpn;
    fill_valid = fv; fill_vaddr = fva; fill_way = 2'(fw); fill_data = fd;
    // expected response from the state before this cycle's updates (R7)
    m = match_of(rva);
    s = int'(rva[11:6]);
    wh = '0;
    for (int w = 0; w < NWAY; w++) wh[w] = |(m_tag[s][w] & m);
    cnt = $countones(wh);
    ed = '0;
    for (int w = 0; w < NWAY; w++)
      if (cnt == 1 && wh[w]) ed = m_dat[s][w][int'(rva[5])*256 +: 256];
    // model updates
    fm = match_of(fva);
    if (tw) begin
      fm[ti] = 1'b0;
      for (int ss = 0; ss < NSET; ss++)
        for (int w = 0; w < NWAY; w++) m_tag[ss][w][ti] = 1'b0;
      m_tv[ti] = 1'b1; m_tvpn[ti] = tvpn;
    end
    if (fv) begin
      fs = int'(fva[11:6]);
      m_tag[fs][fw] = fm;
      m_dat[fs][fw] = fd;
    end
    @(negedge clk);
    check(rsp_valid == rv, "R2", "rsp_valid", 256'(rsp_valid), 256'(rv));
    if (rv) begin
      check(rsp_hit == (cnt == 1), rq, "rsp_hit", 256'(rsp_hit), 256'(cnt == 1));
      check(rsp_miss == (cnt == 0), rq, "rsp_miss", 256'(rsp_miss), 256'(cnt == 0));
      check(rsp_perr == (cnt > 1), rq, "rsp_perr", 256'(rsp_perr), 256'(cnt > 1));
      check(rsp_tlb_miss == (m == '0), rq, "rsp_tlb_miss", 256'(rsp_tlb_miss), 256'(m == '0));
      check(rsp_way == wh, rq, "rsp_way", 256'(rsp_way), 256'(wh));
      check(rsp_data == ed, rq, "rsp_data", rsp_data, ed);
    end else begin
      check(!rsp_hit && !rsp_miss && !rsp_perr && rsp_way == '0, "R2", "idle flags",
            256'({rsp_hit, rsp_miss, rsp_perr, rsp_way}), 256'(0));
    end
  endtask

  task automatic look(logic [VA_W-1:0] va, string rq);
    step(1, va, 0, 0, '0, 0, '0, 0, '0, rq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [VPN_W-1:0] pa, pb, pc, pd;
    logic [511:0]     la;
    void'($urandom(32'd20240611));
    for (int e = 0; e < NTLB; e++) begin m_tv[e] = 0; m_tvpn[e] = '0; end
    for (int s = 0; s < NSET; s++)
      for (int w = 0; w < NWAY; w++) begin m_tag[s][w] = '0; m_dat[s][w] = '0; end
    pa = 36'h0_0040_1; pb = 36'h7_1230_0; pc = 36'h3_0000_5; pd = 36'h0_0ABC_D;
    rst_n = 1'b0;
    req_valid = 0; req_vaddr = '0; tlb_wr_en = 0; tlb_wr_idx = '0; tlb_wr_vpn = '0;
    fill_valid = 0; fill_vaddr = '0; fill_way = '0; fill_data = '0;
    // R1: reset holds the response low, even with a request applied
    repeat (3) @(negedge clk);
    req_valid = 1;
    @(negedge clk);
    check(rsp_valid == 0, "R1", "rsp_valid in reset", 256'(rsp_valid), 256'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 0, "R1", "rsp_valid during release", 256'(rsp_valid), 256'(0));
    req_valid = 0;
    repeat (2) @(negedge clk);

    // R1 R4: empty TLB after reset
    look(mk_va(pa, 5, 0), "R1 R4 empty TLB");
    step(0, '0, 1, 3, pa, 0, '0, 0, '0, "R2 idle cycle");
    // R11: TLB hit, empty set
    look(mk_va(pa, 5, 0), "R11 TLB hit no tag");
    // R5 R3: fill then read both halves, low bits vary
    la = rnd_line();
    step(0, '0, 0, 0, '0, 1, mk_va(pa, 5, 0), 2, la, "R5 fill");
    look(mk_va(pa, 5, 6'h00), "R3 R5 half 0");
    look(mk_va(pa, 5, 6'h3F), "R3 half 1 low bits ignored");
    look(mk_va(pa, 5, 6'h1B), "R3 half 0 low bits ignored");
    look(mk_va(pb, 5, 0), "R4 page absent");
    step(0, '0, 1, 7, pb, 0, '0, 0, '0, "R2 idle cycle");
    look(mk_va(pb, 5, 0), "R11 second page no tag");
    // R10: another way of the same set
    step(0, '0, 0, 0, '0, 1, mk_va(pb, 5, 0), 0, rnd_line(), "R10 fill");
    look(mk_va(pa, 5, 32), "R10 other way kept");
    look(mk_va(pb, 5, 32), "R10 new way hits");
    look(mk_va(pa, 6, 0), "R10 other set untouched");
    // R8: second way for the same page
    step(0, '0, 0, 0, '0, 1, mk_va(pa, 5, 0), 1, rnd_line(), "R8 fill");
    look(mk_va(pa, 5, 0), "R8 multi way");
    // R6: rewrite entry 3 with the same page
    step(0, '0, 1, 3, pa, 0, '0, 0, '0, "R6 rewrite");
    look(mk_va(pa, 5, 0), "R6 stale lines miss");
    look(mk_va(pb, 5, 0), "R6 other entry kept");
    // R7: same-cycle lookup, TLB write and fill
    step(1, mk_va(pb, 5, 33), 1, 7, pb, 1, mk_va(pb, 9, 0), 3, rnd_line(), "R7 old state seen");
    look(mk_va(pb, 9, 0), "R7 masked fill vector");
    look(mk_va(pb, 5, 0), "R7 column cleared");
    // R5: fill while page absent, add page afterwards
    step(0, '0, 0, 0, '0, 1, mk_va(pc, 12, 0), 1, rnd_line(), "R5 fill absent page");
    step(0, '0, 1, 20, pc, 0, '0, 0, '0, "R5 add page");
    look(mk_va(pc, 12, 0), "R5 dead line");
    step(0, '0, 0, 0, '0, 1, mk_va(pc, 12, 0), 2, rnd_line(), "R5 refill");
    look(mk_va(pc, 12, 40), "R3 R5 refill hits");
    look(mk_va(pd, 12, 0), "R4 absent page");

    // Random mix: R3 R4 R6 R8 R10 R11
    for (int i = 0; i < 4000; i++) begin
      logic [VPN_W-1:0] vp [4];
      int sets [4];
      vp[0] = pa; vp[1] = pb; vp[2] = pc; vp[3] = pd;
      sets[0] = 5; sets[1] = 9; sets[2] = 12; sets[3] = 63;
      step(($urandom % 4) != 0, mk_va(vp[$urandom % 4], sets[$urandom % 4], int'($urandom % 64)),
           ($urandom % 16) == 0, int'($urandom % 8), vp[$urandom % 4],
           ($urandom % 4) == 0, mk_va(vp[$urandom % 4], sets[$urandom % 4], 0),
           int'($urandom % 4), rnd_line(), "R3 R4 R8 R11 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule